// File: doc/BRIEF.md
# Programmable Delay Trigger Generator

This block produces timed trigger pulses for conversion hardware. A start event clears a 16-bit main counter and sets it running. The counter climbs to a programmable modulus, then wraps to zero and keeps going. Two delay channels compare the counter against their own delay value. Each channel raises a pre-trigger output in the one cycle where the two match.

Each delay value is double-buffered. A register write only updates a pending copy. The compare uses an active copy, and that copy takes the pending value only at a start event or at a counter wrap. Reading a delay register returns the active copy.

A second output serves a DAC. It has two modes. In counter mode, a start event restarts an interval counter that pulses each time it reaches a programmable interval. In bypass mode, the counter stops and an external input drives the DAC trigger directly. A small write/read register port configures everything.

Top module: `pdly_trig_gen`

## Requirements
- R1: After reset, every register reads zero, the two counters are stopped, and `pre_trig` and `dac_trig` are low (except that in bypass mode `dac_trig` follows its input, and bypass is off at reset).
- R2: Start event selection depends on the `src_sw` bit (bit 0 at address 0):
  - When `src_sw` is 0, a start event is a rising edge of `trig_in` seen at a clock edge. The edge is found by comparing `trig_in` with its value at the previous edge.
  - When `src_sw` is 1, a start event is a write to address 0 with data bit 1 set, and `trig_in` edges have no effect.
  - A start event clears the main counter to 0 and sets it running.
- R3: The modulus is held at address 1. While running, the main counter steps by one each clock. On the clock after it equals or exceeds the modulus, it returns to 0.
- R4: `pre_trig[i]` is high exactly in the cycles where the running main counter equals the active delay of channel i. This gives at most one pulse per counter pass.
- R5: Delay channel i sits at address 2+i. A write goes to a pending copy. At the edge of a start event or of a counter wrap, the active copy takes the pending value. A read returns the active copy in bits 15:0.
- R6: Reserved bits read zero. These are bits 31:16 of every 16-bit register and bits 31:1 at address 0; start bit 1 always reads 0. At address 5, only bit 1 reads back. Unmapped addresses 6 and 7 read zero.
- R7: The interval is at address 4, and counter mode is bit 1 of address 5 equal to 0. In counter mode, a start event clears the interval counter and starts it. `dac_trig` is high in each cycle where the running interval counter equals or exceeds the interval, and on the next clock the counter returns to 0.
- R8: When bit 1 of address 5 is 1, the interval counter is held stopped at zero, and `dac_trig` equals `dac_ext_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| trig_in | input | 1 | Hardware start trigger input |
| dac_ext_in | input | 1 | External DAC trigger input for bypass mode |
| pre_trig | output | 2 | Pre-trigger pulse per delay channel |
| dac_trig | output | 1 | DAC interval trigger |

## Verification
- Start events, wraps and register writes all take effect at the clock edge where they are seen. Their effect on `pre_trig`, `dac_trig` and `rd_data` is visible in the cycle after that edge.
- A new delay value therefore shows in readback and in the compare only after the first start or wrap edge that follows the write.
- The bypass path is combinational, so `dac_ext_in` is checked in the same cycle it changes.
- The bench samples on the falling edge, after the rising edge that updates its model, and changes inputs only after it has sampled.
- Directed checks count the edges explicitly: a trigger edge raised before edge 1 with a delay of 2 must give a pulse in the third sampled cycle.

// File: rtl/pdly_pkg.sv
package pdly_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADR_CTRL = 3'd0;
  localparam addr_t ADR_MOD  = 3'd1;
  localparam addr_t ADR_DLY0 = 3'd2;
  localparam addr_t ADR_IVL  = 3'd4;
  localparam addr_t ADR_DACC = 3'd5;

  localparam int unsigned BIT_SRC_SW = 0;
  localparam int unsigned BIT_GO     = 1;
  localparam int unsigned BIT_BYPASS = 1;

  // limit reached: equal, or already beyond after a lowered limit
  function automatic logic at_limit(input cnt_t c, input cnt_t lim);
    return c >= lim;
  endfunction

  function automatic cnt_t step_wrap(input cnt_t c, input cnt_t lim);
    return at_limit(c, lim) ? '0 : cnt_t'(c + 1'b1);
  endfunction

  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic addr_t dly_addr(input int unsigned ch);
    return addr_t'(int'(ADR_DLY0) + int'(ch));
  endfunction
endpackage

// File: rtl/pdly_regs.sv
module pdly_regs
  import pdly_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  addr_t                   wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  addr_t                   rd_addr,
  input  cnt_t [NUM_CH-1:0]       dly_act,
  output logic                    src_sw,
  output logic                    go_wr,
  output cnt_t                    modulus,
  output cnt_t [NUM_CH-1:0]       dly_pend,
  output cnt_t                    interval,
  output logic                    bypass,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic wr_ctrl, wr_mod, wr_ivl, wr_dacc;
  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_mod  = wr_en && (wr_addr == ADR_MOD);
  assign wr_ivl  = wr_en && (wr_addr == ADR_IVL);
  assign wr_dacc = wr_en && (wr_addr == ADR_DACC);
  assign go_wr   = wr_ctrl && wr_data[BIT_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sw   <= 1'b0;
      modulus  <= '0;
      interval <= '0;
      bypass   <= 1'b0;
    end else begin
      if (wr_ctrl) src_sw   <= wr_data[BIT_SRC_SW];
      if (wr_mod)  modulus  <= wr_data[CNT_W-1:0];
      if (wr_ivl)  interval <= wr_data[CNT_W-1:0];
      if (wr_dacc) bypass   <= wr_data[BIT_BYPASS];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) dly_pend[i] <= '0;
      else if (wr_en && (wr_addr == dly_addr(i))) dly_pend[i] <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data[BIT_SRC_SW] = src_sw;
      ADR_MOD:  rd_data = {{PAD_W{1'b0}}, modulus};
      ADR_IVL:  rd_data = {{PAD_W{1'b0}}, interval};
      ADR_DACC: rd_data[BIT_BYPASS] = bypass;
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == dly_addr(i)) rd_data = {{PAD_W{1'b0}}, dly_act[i]};
    end
  end
endmodule

// File: rtl/pdly_main_cnt.sv
module pdly_main_cnt
  import pdly_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  cnt_t              modulus,
  input  cnt_t [NUM_CH-1:0] dly_pend,
  output cnt_t [NUM_CH-1:0] dly_act,
  output logic [NUM_CH-1:0] pre_trig
);
  cnt_t cnt;
  logic running;
  logic wrap_evt;
  logic load_evt;

  assign wrap_evt = running && at_limit(cnt, modulus);
  assign load_evt = start_evt || wrap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start_evt) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      cnt <= step_wrap(cnt, modulus);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)        dly_act[i] <= '0;
      else if (load_evt) dly_act[i] <= dly_pend[i];
    end

    assign pre_trig[i] = running && (cnt == dly_act[i]);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_trig[i] && !load_evt) |=> !pre_trig[i]);

    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_evt |=> $stable(dly_act[i]));
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (running && cnt == '0));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !start_evt) |=> (cnt == '0));
endmodule

// File: rtl/pdly_dac_path.sv
module pdly_dac_path
  import pdly_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic bypass,
  input  cnt_t interval,
  input  logic ext_in,
  output logic dac_trig
);
  cnt_t ivl_cnt;
  logic ivl_run;
  logic ivl_hit;

  assign ivl_hit = ivl_run && at_limit(ivl_cnt, interval);

  always_ff @(posedge clk) begin
    if (!rst_n || bypass) begin
      ivl_cnt <= '0;
      ivl_run <= 1'b0;
    end else if (start_evt) begin
      ivl_cnt <= '0;
      ivl_run <= 1'b1;
    end else if (ivl_run) begin
      ivl_cnt <= step_wrap(ivl_cnt, interval);
    end
  end

  assign dac_trig = bypass ? ext_in : ivl_hit;

  assert_ivl_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_hit && !bypass && !start_evt) |=> (ivl_cnt == '0));

  assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (!ivl_run && ivl_cnt == '0));
endmodule

// File: rtl/pdly_trig_gen.sv
module pdly_trig_gen
  import pdly_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              trig_in,
  input  logic              dac_ext_in,
  output logic [NUM_CH-1:0] pre_trig,
  output logic              dac_trig
);
  logic              src_sw, go_wr, bypass;
  cnt_t              modulus, interval;
  cnt_t [NUM_CH-1:0] dly_pend, dly_act;
  logic              trig_q;
  logic              start_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign start_evt = src_sw ? go_wr : rise(trig_in, trig_q);

  pdly_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .dly_act(dly_act),
    .src_sw(src_sw), .go_wr(go_wr), .modulus(modulus),
    .dly_pend(dly_pend), .interval(interval), .bypass(bypass),
    .rd_data(rd_data)
  );

  pdly_main_cnt #(.NUM_CH(NUM_CH)) u_main (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .modulus(modulus),
    .dly_pend(dly_pend), .dly_act(dly_act), .pre_trig(pre_trig)
  );

  pdly_dac_path u_dac (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .bypass(bypass),
    .interval(interval), .ext_in(dac_ext_in), .dac_trig(dac_trig)
  );

  assert_ignore_hw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sw && !go_wr) |-> !start_evt);
endmodule

// File: tb/test_pdly_trig_gen.sv
module test_pdly_trig_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        trig_in = 1'b0;
  logic        dac_ext_in = 1'b0;
  logic [1:0]  pre_trig;
  logic        dac_trig;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pdly_trig_gen i_pdly_trig_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig_in(trig_in), .dac_ext_in(dac_ext_in), .pre_trig(pre_trig),
    .dac_trig(dac_trig)
  );

  // bench model, written from the requirements
  logic        m_swsel, m_run, m_drun, m_ext, m_trq;
  logic [15:0] m_mod, m_intv, m_cnt, m_dcnt;
  logic [15:0] m_pend [2];
  logic [15:0] m_act [2];
  logic        m_st;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_swsel = 0; m_run = 0; m_drun = 0; m_ext = 0; m_trq = 0;
      m_mod = 0; m_intv = 0; m_cnt = 0; m_dcnt = 0;
      for (int i = 0; i < 2; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    end else begin
      m_st = m_swsel ? (wr_en && wr_addr == 3'd0 && wr_data[1])
                     : (trig_in && !m_trq);
      if (m_st || (m_run && m_cnt >= m_mod))
        for (int i = 0; i < 2; i++) m_act[i] = m_pend[i];
      if (m_st) begin m_cnt = 0; m_run = 1; end
      else if (m_run) m_cnt = (m_cnt >= m_mod) ? 16'd0 : m_cnt + 16'd1;
      if (m_ext) begin m_dcnt = 0; m_drun = 0; end
      else if (m_st) begin m_dcnt = 0; m_drun = 1; end
      else if (m_drun) m_dcnt = (m_dcnt >= m_intv) ? 16'd0 : m_dcnt + 16'd1;
      m_trq = trig_in;
      if (wr_en)
        case (wr_addr)
          3'd0: m_swsel = wr_data[0];
          3'd1: m_mod = wr_data[15:0];
          3'd2: m_pend[0] = wr_data[15:0];
          3'd3: m_pend[1] = wr_data[15:0];
          3'd4: m_intv = wr_data[15:0];
          3'd5: m_ext = wr_data[1];
          default: ;
        endcase
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_swsel};
      3'd1: return {16'd0, m_mod};
      3'd2: return {16'd0, m_act[0]};
      3'd3: return {16'd0, m_act[1]};
      3'd4: return {16'd0, m_intv};
      3'd5: return {30'd0, m_ext, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd1: return "R3";
      3'd2, 3'd3: return "R5";
      3'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // wait for the falling edge and compare every output with the model
  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      for (int i = 0; i < 2; i++)
        chk("R3/R4", 32'(pre_trig[i]), 32'(m_run && m_cnt == m_act[i]));
      if (m_ext) chk("R8", 32'(dac_trig), 32'(dac_ext_in));
      else       chk("R7", 32'(dac_trig), 32'(m_drun && m_dcnt >= m_intv));
      chk(read_tag(rd_addr), rd_data, exp_read(rd_addr));
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1: reset state on every address and output
    chk("R1", 32'(pre_trig), 0);
    chk("R1", 32'(dac_trig), 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R1", rd_data, 0);
    end

    // R2 directed: trig_in edge starts, delay 2 pulses in third sampled cycle
    wr(3'd1, 32'd20);
    wr(3'd2, 32'hFFFF_0002);
    rd_addr = 3'd2; #1;
    chk("R5", rd_data, 0);
    trig_in = 1;
    tick(); chk("R2", 32'(pre_trig[0]), 0);
    tick(); chk("R2", 32'(pre_trig[0]), 0);
    tick(); chk("R2", 32'(pre_trig[0]), 1);
    tick(); chk("R2", 32'(pre_trig[0]), 0);
    #1 chk("R5", rd_data, 32'd2);

    // R2: software source ignores trig_in edges
    wr(3'd0, 32'd1);
    trig_in = 0; tick(); trig_in = 1; tick(); tick();
    chk("R2", 32'(m_run), 1);
    wr(3'd0, 32'd3);
    tick();

    // R8 directed: bypass follows dac_ext_in in the same cycle
    wr(3'd5, 32'h0000_0002);
    dac_ext_in = 1; #1 chk("R8", 32'(dac_trig), 1);
    dac_ext_in = 0; #1 chk("R8", 32'(dac_trig), 0);
    rd_addr = 3'd5; #1 chk("R6", rd_data, 32'd2);
    wr(3'd5, 32'd0);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'd3);

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      tick();
      r = $urandom;
      wr_en = (r[2:0] == 3'd0);
      wr_addr = 3'($urandom % 8);
      wr_data = r[31:28] == 4'd0 ? $urandom : 32'($urandom % 40) | (r[27] ? 32'hABCD_0000 : 0);
      if (r[6:4] == 3'd0) trig_in = ~trig_in;
      dac_ext_in = r[8];
      rd_addr = 3'($urandom % 8);
    end
    wr_en = 0;
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule